// File: doc/BRIEF.md
# Privilege and Addressing Mode Decoder

This block keeps the privilege-related part of a processor status register and turns it into the operating mode in force and the set of features that mode may use. It holds a two-bit mode-select field, an exception-level flag, an error-level flag and four enable bits: one for 64-bit addressing in each of kernel, supervisor and user mode, and one for the newest instruction subset in user mode. Two override flags force kernel mode whatever the mode-select field holds. Pulses from the exception logic set and clear these flags.

Software changes the field and the enables through a write port. A write is accepted only while the effective mode is kernel. A write from a lower mode leaves the state as it was and raises a privilege-violation output for one cycle. The block also narrows outgoing virtual addresses when 64-bit addressing is off, so that a downstream stage sees a 32-bit address sign-extended to full width.

Top module: `priv_mode_decoder`

## Requirements
- R1: After reset the error-level flag is set, so the mode is kernel. All four enable bits and the mode-select field are zero, the exception-level flag is clear, and `priv_viol` is 0.
- R2: While the exception-level or the error-level flag is set, `mode` is kernel (2'b00) whatever the mode-select field holds.
- R3: With both flags clear, the mode-select field sets `mode` as follows: 2'b00 kernel, 2'b01 supervisor, 2'b10 or 2'b11 user (`mode` = 2'b10).
- R4: A write (`wr_en`=1) while `mode` is not kernel changes no state. `priv_viol` is 1 in the following cycle only.
- R5: In kernel mode `addr64_en` equals the kernel enable bit, and `isa3_en` and `isa4_en` are both 1.
- R6: In supervisor mode `addr64_en` and `isa3_en` both equal the supervisor enable bit, and `isa4_en` is 1.
- R7: In user mode `addr64_en` and `isa3_en` both equal the user enable bit, and `isa4_en` equals the separate user subset bit.
- R8: `vaddr_out` equals `vaddr_in` when `addr64_en` is 1. Otherwise it is bits 31:0 of `vaddr_in` sign-extended from bit 31. The path is combinational.
- R9: An `exc_enter` pulse sets the exception-level flag, and an `err_enter` pulse sets the error-level flag, from the next cycle on.
- R10: An `exc_return` pulse clears the error-level flag if it is set, and otherwise clears the exception-level flag. An entry pulse in the same cycle sets its flag regardless of the return.
- R11: A write made in kernel mode loads `wr_ksu`, `wr_kx`, `wr_sx`, `wr_ux` and `wr_xx` at the clock edge. Its effect shows on the outputs in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Status write strobe |
| wr_ksu | input | 2 | Mode-select value to write |
| wr_kx | input | 1 | Kernel 64-bit addressing enable to write |
| wr_sx | input | 1 | Supervisor 64-bit enable to write |
| wr_ux | input | 1 | User 64-bit enable to write |
| wr_xx | input | 1 | User newest-subset enable to write |
| exc_enter | input | 1 | Exception entry pulse |
| err_enter | input | 1 | Error entry pulse |
| exc_return | input | 1 | Exception return pulse |
| vaddr_in | input | ADDR_W | Virtual address from the pipeline |
| mode | output | 2 | Effective mode: 00 kernel, 01 supervisor, 10 user |
| addr64_en | output | 1 | 64-bit addressing enabled |
| isa3_en | output | 1 | 64-bit instruction subset enabled |
| isa4_en | output | 1 | Newest instruction subset enabled |
| priv_viol | output | 1 | Write attempted outside kernel mode |
| vaddr_out | output | ADDR_W | Address after narrowing |

## Verification
Every registered result is due exactly one cycle after the edge that samples its stimulus. This covers flag set and clear, accepted writes and the violation pulse. `mode` and the enables follow the new state with no further delay, and `vaddr_out` follows `vaddr_in` in the same cycle. The bench drives inputs on the falling edge and lets the reference model step at the same moment. It compares on the next falling edge, once the rising edge has updated the registers. Forced-kernel, return-priority and rejected-write cases are built in directed steps, and then a long weighted random run follows.

// File: rtl/priv_mode_decoder.sv
module priv_mode_decoder #(
  parameter int ADDR_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_ksu,
  input  logic              wr_kx,
  input  logic              wr_sx,
  input  logic              wr_ux,
  input  logic              wr_xx,
  input  logic              exc_enter,
  input  logic              err_enter,
  input  logic              exc_return,
  input  logic [ADDR_W-1:0] vaddr_in,
  output logic [1:0]        mode,
  output logic              addr64_en,
  output logic              isa3_en,
  output logic              isa4_en,
  output logic              priv_viol,
  output logic [ADDR_W-1:0] vaddr_out
);

  localparam logic [1:0] M_KERN = 2'b00;
  localparam logic [1:0] M_SUP  = 2'b01;
  localparam logic [1:0] M_USER = 2'b10;
  localparam int EXT_W = ADDR_W - NARROW_W;

  logic [1:0] ksu_q;
  logic       exl_q, erl_q;
  logic       kx_q, sx_q, ux_q, xx_q;
  logic       viol_q;
  logic       wr_ok, wr_bad;

  always_comb begin
    if (exl_q || erl_q) mode = M_KERN;
    else begin
      case (ksu_q)
        2'b00:   mode = M_KERN;
        2'b01:   mode = M_SUP;
        default: mode = M_USER;
      endcase
    end
  end

  assign wr_ok  = wr_en && (mode == M_KERN);
  assign wr_bad = wr_en && (mode != M_KERN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ksu_q  <= 2'b00;
      exl_q  <= 1'b0;
      erl_q  <= 1'b1;
      kx_q   <= 1'b0;
      sx_q   <= 1'b0;
      ux_q   <= 1'b0;
      xx_q   <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      viol_q <= wr_bad;
      erl_q  <= err_enter || (erl_q && !exc_return);
      exl_q  <= exc_enter || (exl_q && !(exc_return && !erl_q));
      if (wr_ok) begin
        ksu_q <= wr_ksu;
        kx_q  <= wr_kx;
        sx_q  <= wr_sx;
        ux_q  <= wr_ux;
        xx_q  <= wr_xx;
      end
    end
  end

  assign priv_viol = viol_q;

  always_comb begin
    case (mode)
      M_KERN: begin
        addr64_en = kx_q;
        isa3_en   = 1'b1;
        isa4_en   = 1'b1;
      end
      M_SUP: begin
        addr64_en = sx_q;
        isa3_en   = sx_q;
        isa4_en   = 1'b1;
      end
      default: begin
        addr64_en = ux_q;
        isa3_en   = ux_q;
        isa4_en   = xx_q;
      end
    endcase
  end

  assign vaddr_out = addr64_en ? vaddr_in
                   : {{EXT_W{vaddr_in[NARROW_W-1]}}, vaddr_in[NARROW_W-1:0]};

  AST_FORCED_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
    (exl_q || erl_q) |-> (mode == M_KERN)); // R2

  AST_BAD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode != M_KERN) |=> ($stable(ksu_q) && $stable(kx_q) && $stable(sx_q)
                                   && $stable(ux_q) && $stable(xx_q) && priv_viol)); // R4

  AST_VIOL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    priv_viol |-> $past(wr_en && mode != M_KERN)); // R4

  AST_SUBSET4_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_USER) |-> isa4_en); // R6

  AST_NARROW_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    !addr64_en |-> (vaddr_out[ADDR_W-1:NARROW_W] == {EXT_W{vaddr_out[NARROW_W-1]}})); // R8

  AST_RETURN_CLEARS_ERL: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return && erl_q && !err_enter) |=> !erl_q); // R10

  AST_ENTRY_SETS_EXL: assert property (@(posedge clk) disable iff (!rst_n)
    exc_enter |=> (exl_q && mode == M_KERN)); // R9

endmodule

// File: tb/priv_mode_decoder_bench.sv
module priv_mode_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 0, wr_kx = 0, wr_sx = 0, wr_ux = 0, wr_xx = 0;
  logic [1:0]  wr_ksu = 0;
  logic        exc_enter = 0, err_enter = 0, exc_return = 0;
  logic [63:0] vaddr_in = 0;
  logic [1:0]  mode;
  logic        addr64_en, isa3_en, isa4_en, priv_viol;
  logic [63:0] vaddr_out;

  int checks = 0, failures = 0;
  bit done = 0;

  int m_ksu, m_exl, m_erl, m_kx, m_sx, m_ux, m_xx, m_viol;

  always #5 clk = ~clk;

  priv_mode_decoder u_priv_mode_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ksu(wr_ksu),
    .wr_kx(wr_kx), .wr_sx(wr_sx), .wr_ux(wr_ux), .wr_xx(wr_xx),
    .exc_enter(exc_enter), .err_enter(err_enter), .exc_return(exc_return),
    .vaddr_in(vaddr_in), .mode(mode), .addr64_en(addr64_en),
    .isa3_en(isa3_en), .isa4_en(isa4_en), .priv_viol(priv_viol),
    .vaddr_out(vaddr_out));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_mode();
    if (m_exl != 0 || m_erl != 0) return 0;
    if (m_ksu == 0) return 0;
    if (m_ksu == 1) return 1;
    return 2;
  endfunction

  task automatic compare();
    int em = exp_mode();
    int ea, e3, e4;
    logic [63:0] ev;
    if (em == 0) begin ea = m_kx; e3 = 1; e4 = 1; end
    else if (em == 1) begin ea = m_sx; e3 = m_sx; e4 = 1; end
    else begin ea = m_ux; e3 = m_ux; e4 = m_xx; end
    ev = (ea != 0) ? vaddr_in : {{32{vaddr_in[31]}}, vaddr_in[31:0]};
    chk((m_exl != 0 || m_erl != 0) ? "R2 mode" : "R3 mode", 64'(mode), 64'(em));
    chk(em == 0 ? "R5 addr64" : (em == 1 ? "R6 addr64" : "R7 addr64"), 64'(addr64_en), 64'(ea));
    chk(em == 0 ? "R5 isa3" : (em == 1 ? "R6 isa3" : "R7 isa3"), 64'(isa3_en), 64'(e3));
    chk(em == 0 ? "R5 isa4" : (em == 1 ? "R6 isa4" : "R7 isa4"), 64'(isa4_en), 64'(e4));
    chk("R4 priv_viol", 64'(priv_viol), 64'(m_viol));
    chk("R8 vaddr_out", vaddr_out, ev);
  endtask

  task automatic step_model();
    int kern = (exp_mode() == 0);
    int erl_old = m_erl;
    m_viol = (wr_en && !kern) ? 1 : 0;
    m_erl = (err_enter || (m_erl != 0 && !exc_return)) ? 1 : 0;
    m_exl = (exc_enter || (m_exl != 0 && !(exc_return && erl_old == 0))) ? 1 : 0;
    if (wr_en && kern) begin
      m_ksu = wr_ksu; m_kx = wr_kx; m_sx = wr_sx; m_ux = wr_ux; m_xx = wr_xx;
    end
  endtask

  task automatic cycle(input logic we, input logic [1:0] k, input logic kx, input logic sx,
                       input logic ux, input logic xx, input logic ee, input logic re,
                       input logic rt, input logic [63:0] va);
    wr_en = we; wr_ksu = k; wr_kx = kx; wr_sx = sx; wr_ux = ux; wr_xx = xx;
    exc_enter = ee; err_enter = re; exc_return = rt; vaddr_in = va;
    step_model();
    @(negedge clk);
    compare();
  endtask

  initial begin
    m_ksu = 0; m_exl = 0; m_erl = 1; m_kx = 0; m_sx = 0; m_ux = 0; m_xx = 0; m_viol = 0;
    vaddr_in = 64'h0000_0000_8000_1234;
    @(negedge clk);
    @(negedge clk);
    chk("R1 mode", 64'(mode), 64'd0);
    chk("R1 addr64", 64'(addr64_en), 64'd0);
    chk("R1 priv_viol", 64'(priv_viol), 64'd0);
    chk("R1 vaddr_out", vaddr_out, 64'hFFFF_FFFF_8000_1234);
    rst_n = 1'b1;
    @(negedge clk);
    compare();
    // R2: mode-select written to user while error-level holds kernel
    cycle(1, 2'b10, 1, 0, 1, 0, 0, 0, 0, 64'h1234_5678_9ABC_DEF0);
    chk("R2 forced kernel", 64'(mode), 64'd0);
    // R10: return clears error-level, exposing user mode
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, 64'h1234_5678_9ABC_DEF0);
    chk("R10 return to user", 64'(mode), 64'd2);
    chk("R7 ux addr", vaddr_out, 64'h1234_5678_9ABC_DEF0);
    // R4: write from user rejected
    cycle(1, 2'b00, 1, 1, 0, 1, 0, 0, 0, 64'h0);
    chk("R4 viol pulse", 64'(priv_viol), 64'd1);
    chk("R4 still user", 64'(mode), 64'd2);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 64'h0);
    chk("R4 viol single cycle", 64'(priv_viol), 64'd0);
    // R9: exception entry forces kernel
    cycle(0, 0, 0, 0, 0, 0, 1, 0, 0, 64'h0);
    chk("R9 exl kernel", 64'(mode), 64'd0);
    // R11: kernel write to supervisor mode; still forced kernel by EXL
    cycle(1, 2'b01, 0, 1, 0, 0, 0, 0, 0, 64'h0);
    // R10: error entry on top, one return clears only error-level
    cycle(0, 0, 0, 0, 0, 0, 0, 1, 0, 64'h0);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, 64'h0);
    chk("R10 exl remains", 64'(mode), 64'd0);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, 64'h0);
    chk("R11 supervisor", 64'(mode), 64'd1);
    chk("R6 isa4 in supervisor", 64'(isa4_en), 64'd1);
    // R10: entry and return together keep the flag set
    cycle(0, 0, 0, 0, 0, 0, 1, 0, 1, 64'h0);
    chk("R10 entry wins", 64'(mode), 64'd0);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, 64'h0);
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      cycle(r < 30, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            r >= 95, r == 94, (r >= 80 && r < 94), {$urandom, $urandom});
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule